// File: doc/BRIEF.md
# Host Transaction Address Router

This block sits between the cores and the rest of the system. It takes one request at a time, holding an address, a write flag and a flag that marks port-IO space as opposed to memory space. It then raises exactly one destination strobe one cycle later. The possible destinations are:

- the DRAM port;
- the boot flash;
- one of several root ports;
- the south-bridge fallback port.

Memory addresses are steered in a fixed order of priority:

1. The two legacy 64 KB BIOS segments just under 1 MB go to flash or DRAM, depending on a shadow control bit.
2. A window at the very top of the 4 GB space is always flash, so the reset fetch works.
3. Memory under the top-of-low-memory boundary goes to DRAM.
4. Memory from 4 GB up to the top-of-high-memory boundary also goes to DRAM.

Every other memory address, and every IO-space request, is offered to the root ports. Each root port has an inclusive base/limit window and claims a request whose address falls inside it. When no window claims the request, it goes to the fallback port.

The boundaries, the windows and the shadow bit are set through a single write-only configuration port. Each write takes effect for requests accepted from the next clock on.

Top module: `host_addr_router`

## Requirements
- R1: A request with `req_io` high never raises `rt_dram`. It goes to the claiming root port, or else to `rt_sb`.
- R2: A memory request whose address is below the low boundary (config index 0, exclusive) raises `rt_dram`, unless R7 or R8 applies.
- R3: A memory request with 4 GB <= address < high boundary (config index 1, exclusive) raises `rt_dram`.
- R4: A memory request between the low boundary and 4 GB, or at or above the high boundary, never raises `rt_dram`. It goes to a root port or to `rt_sb`, unless R8 applies.
- R5: Root port p claims an IO-subsystem request when base_p <= address <= limit_p, with both ends included. base_p is at config index 4+2p and limit_p at config index 5+2p. The claim is shown on bit p of `rt_rp`.
- R6: An IO-subsystem request that no root port claims raises `rt_sb`.
- R7: Memory addresses 0xE0000 to 0xFFFFF raise `rt_flash` while the shadow bit (bit 0 of config index 2) is 0, and raise `rt_dram` while it is 1.
- R8: Memory addresses from 4 GB minus 2^FLASH_LOG2 up to 0xFFFFFFFF always raise `rt_flash`. With the default of 24 this window starts at 0xFF000000.
- R9: When several windows contain the address, only the lowest-numbered port is raised.
- R10: A window whose limit is below its base claims nothing.
- R11: `rt_valid` goes high in the cycle after a request is accepted (`req_valid` and `req_ready`) and is low otherwise. While it is high exactly one strobe among `rt_dram`, `rt_flash`, `rt_rp`, `rt_sb` is high. While it is low, all strobes are low.
- R12: After reset `req_ready` rises, and the registers hold these values:
  - low boundary = 0;
  - high boundary = 4 GB;
  - every window disabled (base all ones, limit 0);
  - shadow bit 0.

  So an ordinary memory request such as 0x1000 goes to `rt_sb`, while 0xFFFF0 goes to `rt_flash`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | ADDR_W | Request physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = IO space, 0 = memory space |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | CFG_AW | Configuration register index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| rt_valid | output | 1 | Routed request valid |
| rt_addr | output | ADDR_W | Address of routed request |
| rt_write | output | 1 | Write flag of routed request |
| rt_dram | output | 1 | Destination: DRAM port |
| rt_flash | output | 1 | Destination: boot flash |
| rt_rp | output | NUM_PORTS | Destination: root port, one-hot |
| rt_sb | output | 1 | Destination: south-bridge fallback |

## Verification
The bench probes the address one below each boundary and exactly at it. A design with an off-by-one compare would leak the last DRAM byte into the IO path, or drop a window's last byte to the fallback port.

It programs two overlapping windows and one window with its limit below its base. A design without priority would raise two strobes at once, and one that ignored the inverted window would steal fallback traffic.

It sends IO-space requests at DRAM addresses, where a design that overlooked the space flag would hit memory. It flips the shadow bit and checks that the legacy segment moves to DRAM while the top-of-4GB flash window stays put.

// File: rtl/host_route_pkg.sv
// Package: shared types and configuration register indices for the router.
// Assumes nothing beyond being compiled before the modules that import it.
package host_route_pkg;

    typedef enum logic [1:0] {
        REGION_DRAM  = 2'd0,
        REGION_FLASH = 2'd1,
        REGION_IOSUB = 2'd2
    } region_e;

    localparam int unsigned IDX_TOLM   = 0;
    localparam int unsigned IDX_TOHM   = 1;
    localparam int unsigned IDX_SHADOW = 2;
    localparam int unsigned IDX_APER0  = 4;

endpackage

// File: rtl/hr_cfg_regs.sv
// Configuration register bank: low/high DRAM boundaries, shadow bit and one
// base/limit pair per root port. Written one register per cycle through a
// plain write strobe. Assumes ADDR_W > 32 and an index width wide enough for
// 4 + 2*NUM_PORTS entries.
module hr_cfg_regs
    import host_route_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int NUM_PORTS = 4,
    parameter int CFG_AW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] tolm,
    output logic [ADDR_W-1:0] tohm,
    output logic              shadow_en,
    output logic [ADDR_W-1:0] ap_base  [NUM_PORTS],
    output logic [ADDR_W-1:0] ap_limit [NUM_PORTS]
);

    localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(1) << 32;

    // Global boundary and shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tolm      <= '0;
            tohm      <= FOUR_G;
            shadow_en <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel == CFG_AW'(IDX_TOLM))   tolm      <= cfg_wdata;
            if (cfg_sel == CFG_AW'(IDX_TOHM))   tohm      <= cfg_wdata;
            if (cfg_sel == CFG_AW'(IDX_SHADOW)) shadow_en <= cfg_wdata[0];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_aper
        localparam int unsigned BASE_IDX  = IDX_APER0 + 2 * p;
        localparam int unsigned LIMIT_IDX = BASE_IDX + 1;

        // Per-port window registers, reset to the disabled (limit < base) state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ap_base[p]  <= '1;
                ap_limit[p] <= '0;
            end else if (cfg_we) begin
                if (cfg_sel == CFG_AW'(BASE_IDX))  ap_base[p]  <= cfg_wdata;
                if (cfg_sel == CFG_AW'(LIMIT_IDX)) ap_limit[p] <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/hr_region_decode.sv
// Region classifier: decides whether a request is DRAM, flash or for the IO
// subsystem. Priority: IO space, legacy BIOS segments (shadow-controlled),
// top-of-4GB flash window, DRAM holes, then IO subsystem. Purely combinational.
module hr_region_decode
    import host_route_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int FLASH_LOG2 = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    input  logic [ADDR_W-1:0] tolm,
    input  logic [ADDR_W-1:0] tohm,
    input  logic              shadow_en,
    output region_e           region
);

    localparam logic [ADDR_W-1:0] FOUR_G   = ADDR_W'(1) << 32;
    localparam logic [ADDR_W-1:0] LEG_LO   = ADDR_W'(32'h000E_0000);
    localparam logic [ADDR_W-1:0] LEG_HI   = ADDR_W'(32'h000F_FFFF);
    localparam logic [ADDR_W-1:0] FLASH_LO = FOUR_G - (ADDR_W'(1) << FLASH_LOG2);

    logic in_legacy, in_top_flash, in_low_dram, in_high_dram;

    // Range comparisons against fixed and programmed boundaries.
    always_comb begin
        in_legacy    = (addr >= LEG_LO) && (addr <= LEG_HI);
        in_top_flash = (addr >= FLASH_LO) && (addr < FOUR_G);
        in_low_dram  = (addr < tolm) && (addr < FOUR_G);
        in_high_dram = (addr >= FOUR_G) && (addr < tohm);
    end

    // Priority selection of the region.
    always_comb begin
        if (is_io)                           region = REGION_IOSUB;
        else if (in_legacy)                  region = shadow_en ? REGION_DRAM : REGION_FLASH;
        else if (in_top_flash)               region = REGION_FLASH;
        else if (in_low_dram || in_high_dram) region = REGION_DRAM;
        else                                 region = REGION_IOSUB;
    end

endmodule

// File: rtl/hr_aperture_claim.sv
// Positive decode: compares an address to every root-port window (inclusive
// on both ends) and returns a one-hot claim with the lowest index winning.
// A window whose limit is below its base never matches. Combinational.
module hr_aperture_claim #(
    parameter int ADDR_W    = 40,
    parameter int NUM_PORTS = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [ADDR_W-1:0]    ap_base  [NUM_PORTS],
    input  logic [ADDR_W-1:0]    ap_limit [NUM_PORTS],
    output logic [NUM_PORTS-1:0] claim,
    output logic                 any_claim
);

    logic [NUM_PORTS-1:0] hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        // Raw window match for port p; an inverted window stays silent.
        always_comb begin
            hit[p] = (ap_base[p] <= ap_limit[p]) &&
                     (addr >= ap_base[p]) && (addr <= ap_limit[p]);
        end
    end

    // Lowest-index priority pick.
    always_comb begin
        logic found;
        found = 1'b0;
        claim = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (hit[i] && !found) begin
                claim[i] = 1'b1;
                found    = 1'b1;
            end
        end
        any_claim = found;
    end

endmodule

// File: rtl/host_addr_router.sv
// Top: accepts one request per cycle, classifies it, and registers a single
// one-hot destination strobe with one cycle of latency. Configuration writes
// take effect for requests accepted after the write edge.
module host_addr_router
    import host_route_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_PORTS  = 4,
    parameter int CFG_AW     = 4,
    parameter int FLASH_LOG2 = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 req_io,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic                 rt_valid,
    output logic [ADDR_W-1:0]    rt_addr,
    output logic                 rt_write,
    output logic                 rt_dram,
    output logic                 rt_flash,
    output logic [NUM_PORTS-1:0] rt_rp,
    output logic                 rt_sb
);

    logic [ADDR_W-1:0]    tolm, tohm;
    logic                 shadow_en;
    logic [ADDR_W-1:0]    ap_base  [NUM_PORTS];
    logic [ADDR_W-1:0]    ap_limit [NUM_PORTS];
    region_e              region;
    logic [NUM_PORTS-1:0] claim;
    logic                 any_claim;
    logic                 ready_q;
    logic                 accept;

    hr_cfg_regs #(
        .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .CFG_AW(CFG_AW)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tolm(tolm), .tohm(tohm),
        .shadow_en(shadow_en), .ap_base(ap_base), .ap_limit(ap_limit)
    );

    hr_region_decode #(
        .ADDR_W(ADDR_W), .FLASH_LOG2(FLASH_LOG2)
    ) region_i (
        .addr(req_addr), .is_io(req_io), .tolm(tolm), .tohm(tohm),
        .shadow_en(shadow_en), .region(region)
    );

    hr_aperture_claim #(
        .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)
    ) claim_i (
        .addr(req_addr), .ap_base(ap_base), .ap_limit(ap_limit),
        .claim(claim), .any_claim(any_claim)
    );

    // Ready comes up on the first cycle after reset and stays up.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign req_ready = ready_q;
    assign accept    = req_valid && ready_q;

    // Registered routing decision; strobes are cleared on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid <= 1'b0;
            rt_addr  <= '0;
            rt_write <= 1'b0;
            rt_dram  <= 1'b0;
            rt_flash <= 1'b0;
            rt_rp    <= '0;
            rt_sb    <= 1'b0;
        end else begin
            rt_valid <= accept;
            if (accept) begin
                rt_addr  <= req_addr;
                rt_write <= req_write;
                rt_dram  <= (region == REGION_DRAM);
                rt_flash <= (region == REGION_FLASH);
                rt_rp    <= (region == REGION_IOSUB) ? claim : '0;
                rt_sb    <= (region == REGION_IOSUB) && !any_claim;
            end else begin
                rt_dram  <= 1'b0;
                rt_flash <= 1'b0;
                rt_rp    <= '0;
                rt_sb    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/host_addr_router_chk.sv
// Checker: temporal properties of the router, attached by bind.
module hr_checker #(
    parameter int ADDR_W     = 40,
    parameter int NUM_PORTS  = 4,
    parameter int FLASH_LOG2 = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_io,
    input logic                 shadow_en,
    input logic                 rt_valid,
    input logic                 rt_dram,
    input logic                 rt_flash,
    input logic [NUM_PORTS-1:0] rt_rp,
    input logic                 rt_sb
);

    localparam logic [ADDR_W-1:0] FOUR_G   = ADDR_W'(1) << 32;
    localparam logic [ADDR_W-1:0] FLASH_LO = FOUR_G - (ADDR_W'(1) << FLASH_LOG2);

    logic acc;
    assign acc = req_valid && req_ready;

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> $onehot({rt_dram, rt_flash, rt_sb, rt_rp})); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_valid |-> ({rt_dram, rt_flash, rt_sb, rt_rp} == '0)); // R11
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rt_valid); // R11
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rt_valid); // R11
    AST_IO_NOT_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_io) |=> !rt_dram); // R1
    AST_TOP_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_io && req_addr >= FLASH_LO && req_addr < FOUR_G) |=> rt_flash); // R8
    AST_LEGACY_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_io && !shadow_en && req_addr >= ADDR_W'(32'hE0000)
         && req_addr <= ADDR_W'(32'hFFFFF)) |=> rt_flash); // R7

endmodule

bind host_addr_router hr_checker #(
    .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .FLASH_LOG2(FLASH_LOG2)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_io(req_io), .shadow_en(shadow_en),
    .rt_valid(rt_valid), .rt_dram(rt_dram), .rt_flash(rt_flash),
    .rt_rp(rt_rp), .rt_sb(rt_sb)
);

// File: tb/host_addr_router_tb_top.sv
`timescale 1ns/1ps
module host_addr_router_tb_top;

    localparam int ADDR_W = 40;
    localparam int NP     = 4;
    localparam int CAW    = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid, req_write, req_io;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic              cfg_we;
    logic [CAW-1:0]    cfg_sel;
    logic [ADDR_W-1:0] cfg_wdata;
    logic              rt_valid, rt_write, rt_dram, rt_flash, rt_sb;
    logic [ADDR_W-1:0] rt_addr;
    logic [NP-1:0]     rt_rp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    host_addr_router #(.ADDR_W(ADDR_W), .NUM_PORTS(NP), .CFG_AW(CAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rt_valid(rt_valid), .rt_addr(rt_addr), .rt_write(rt_write),
        .rt_dram(rt_dram), .rt_flash(rt_flash), .rt_rp(rt_rp), .rt_sb(rt_sb)
    );

    // Expected strobes: {sb, rp[3:0], flash, dram}
    localparam logic [6:0] E_DRAM = 7'b0000001;
    localparam logic [6:0] E_FL   = 7'b0000010;
    localparam logic [6:0] E_RP0  = 7'b0000100;
    localparam logic [6:0] E_RP1  = 7'b0001000;
    localparam logic [6:0] E_RP2  = 7'b0010000;
    localparam logic [6:0] E_SB   = 7'b1000000;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              io;
        logic [3:0]        req;
        logic [6:0]        exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{40'h00_0000_1000, 1'b0, 4'd2,  E_DRAM}, // R2
        '{40'h00_7FFF_FFFF, 1'b0, 4'd2,  E_DRAM}, // R2 last byte below TOLM
        '{40'h00_8000_0000, 1'b0, 4'd6,  E_SB},   // R6 / R4 at TOLM
        '{40'h00_9000_0000, 1'b0, 4'd5,  E_RP0},  // R5 base inclusive
        '{40'h00_9800_0000, 1'b0, 4'd9,  E_RP0},  // R9 overlap, port 0 wins
        '{40'h00_A000_0000, 1'b0, 4'd9,  E_RP1},  // R9 only port 1
        '{40'h00_A7FF_FFFF, 1'b0, 4'd5,  E_RP1},  // R5 limit inclusive
        '{40'h00_A800_0000, 1'b0, 4'd6,  E_SB},   // R6 one past limit
        '{40'h00_B000_0000, 1'b0, 4'd10, E_SB},   // R10 inverted window
        '{40'h01_0000_0000, 1'b0, 4'd3,  E_DRAM}, // R3 at 4 GB
        '{40'h01_FFFF_FFFF, 1'b0, 4'd3,  E_DRAM}, // R3 below TOHM
        '{40'h02_0000_0000, 1'b0, 4'd4,  E_SB},   // R4 at TOHM
        '{40'h03_0000_8000, 1'b0, 4'd4,  E_RP2},  // R4 high MMIO window
        '{40'h00_000F_FFF0, 1'b0, 4'd7,  E_FL},   // R7 legacy reset vector
        '{40'h00_000E_0000, 1'b0, 4'd7,  E_FL},   // R7 segment start
        '{40'h00_000D_FFFF, 1'b0, 4'd7,  E_DRAM}, // R7 just below segments
        '{40'h00_FFFF_FFF0, 1'b0, 4'd8,  E_FL},   // R8 top reset vector
        '{40'h00_FF00_0000, 1'b0, 4'd8,  E_FL},   // R8 window start
        '{40'h00_FEFF_FFFF, 1'b0, 4'd8,  E_SB},   // R8 one below window
        '{40'h00_0000_1000, 1'b1, 4'd1,  E_SB},   // R1 IO at DRAM address
        '{40'h00_9000_0010, 1'b1, 4'd1,  E_RP0}   // R1 IO claimed by port
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input logic [ADDR_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = CAW'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one request, then sample the registered result one edge later.
    task automatic send(input logic [ADDR_W-1:0] a, input logic io, output logic [6:0] got, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_io = io; req_write = a[4];
        @(negedge clk);
        req_valid = 1'b0;
        got = {rt_sb, rt_rp, rt_flash, rt_dram};
        v   = rt_valid;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        logic [6:0] got;
        logic       v;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_io = 1'b0;
        req_write = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        check("R12 ready low in reset", 64'(req_ready), 64'd0);
        check("R11 valid low in reset", 64'(rt_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 ready after reset", 64'(req_ready), 64'd1);

        // Reset defaults: ordinary memory to fallback, legacy vector to flash.
        send(40'h1000, 1'b0, got, v);
        check("R12 default mem to sb", 64'({v, got}), 64'({1'b1, E_SB}));
        send(40'hFFFF0, 1'b0, got, v);
        check("R12 default legacy to flash", 64'({v, got}), 64'({1'b1, E_FL}));
        @(negedge clk);
        check("R11 valid drops when idle", 64'({rt_valid, rt_sb, rt_rp, rt_flash, rt_dram}), 64'd0);

        cfg_write(0, 40'h00_8000_0000);
        cfg_write(1, 40'h02_0000_0000);
        cfg_write(4, 40'h00_9000_0000); cfg_write(5, 40'h00_9FFF_FFFF);
        cfg_write(6, 40'h00_9800_0000); cfg_write(7, 40'h00_A7FF_FFFF);
        cfg_write(8, 40'h03_0000_0000); cfg_write(9, 40'h03_0000_FFFF);
        cfg_write(10, 40'h00_B000_0000); cfg_write(11, 40'h00_AFFF_FFFF);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].addr, VECS[i].io, got, v);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'({v, got}), 64'({1'b1, VECS[i].exp}));
        end

        // Shadow on: legacy segments move to DRAM, top window stays flash.
        cfg_write(2, 40'h1);
        send(40'hFFFF0, 1'b0, got, v);
        check("R7 shadowed vector to dram", 64'({v, got}), 64'({1'b1, E_DRAM}));
        send(40'hE0000, 1'b0, got, v);
        check("R7 shadowed segment start", 64'({v, got}), 64'({1'b1, E_DRAM}));
        send(40'hFFFF_FFF0, 1'b0, got, v);
        check("R8 top flash ignores shadow", 64'({v, got}), 64'({1'b1, E_FL}));
        send(40'hFFFF0, 1'b1, got, v);
        check("R1 IO in legacy range", 64'({v, got}), 64'({1'b1, E_SB}));
        check("R11 address forwarded", 64'(rt_addr), 64'(40'hFFFF0));

        done = 1;
        finish_run();
    end

endmodule